// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the device side of a double-data-rate SDRAM command bus. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines, the clock-enable line, a 13-bit address and a 2-bit bank number. It turns them into one command code and checks that command against what it knows of each of the four banks. For each bank it holds one of three states: idle, open or precharging. It also holds the row that is open, a count of the burst cycles still to run, and whether that burst ends with an automatic precharge.

Commands that break the rules raise one bit in an error vector and have no other effect. Loads of the base and extended mode registers produce a one-cycle strobe together with the op-code. The burst length field of the base mode register sets how long a read or write burst lasts. Each bank has a counter that holds it in the precharging state for `TRP_CYC` cycles, and only then accepts a new row activation.

All outputs are registered. The result of a command sampled at a clock edge can be seen just after that same edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high the command code is 0 (deselect). With `cs_n` low, {ras_n,cas_n,we_n} decodes as follows: 111 gives 1 (no-op), 011 gives 2 (activate), 101 gives 3 (read), 100 gives 4 (write), 110 gives 5 (burst stop), 010 gives 6 (precharge), 000 gives 9 (mode load) and 001 gives 7 (refresh) when `cke` is high. The code appears on `cmd_code` after the sampling edge.
- R2: Deselect and no-op change no bank state, no row, no mode register and no burst.
- R3: Activate to a ready bank opens it (`bank_state` field 2b+1:2b = 1) and records `addr` as its row. A bank is ready when it is idle (0), or when it is precharging (2) and its wait has run out. Activate to a bank that is not ready sets `err_flags[1]` and is ignored.
- R4: Read or write to an open bank with no automatic precharge pending starts a burst. The burst lasts 1, 2 or 4 cycles for base mode bits [2:0] = 1 (or any other code), 2 and 3 respectively. Any other read or write sets `err_flags[0]` and is ignored.
- R5: `addr[10]` high on a read or write sets `ap_pend`. The bank then enters precharging at the edge that ends the burst. With `addr[10]` low the bank stays open.
- R6: Precharge with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes every bank. It affects only open banks with no automatic precharge pending, and it is never flagged. A burst in a bank that it closes ends.
- R7: A bank that starts precharging at edge e becomes ready at edge e+TRP_CYC. An activate at that edge is legal. One edge earlier it is flagged.
- R8: Burst stop is legal only while a read burst without automatic precharge runs. It then ends every such burst. Otherwise it sets `err_flags[2]` and is ignored.
- R9: The refresh encoding gives code 7 with `cke` high and code 8 (self-refresh entry) with `cke` low. Either one sets `err_flags[3]` unless all banks are ready.
- R10: Mode load with `ba`=0 writes `base_mode` and pulses `mode_ld`. With `ba`=1 it writes `ext_mode` and pulses `emode_ld`. In both cases `ld_opcode` takes `addr`. Any other `ba` sets `err_flags[4]` and nothing is written.
- R11: With `cs_n` low, `cke` low and an encoding other than refresh, `err_flags[5]` is set and the command is ignored.
- R12: Reset, synchronous and active-low, leaves all banks idle, with rows, bursts, both mode registers, strobes, error flags and the command code all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| addr | input | 13 | Row, column or op-code; bit 10 selects auto/all precharge |
| ba | input | 2 | Bank number |
| cmd_code | output | 4 | Decoded command code (R1) |
| err_flags | output | 6 | Rule-violation flags, one per rule |
| bank_state | output | 8 | Two bits per bank: 0 idle, 1 open, 2 precharging |
| bank_row | output | 52 | Open row of each bank, 13 bits per bank |
| burst_on | output | 4 | Burst running in each bank |
| ap_pend | output | 4 | Automatic precharge pending in each bank |
| mode_ld | output | 1 | One-cycle strobe on a base mode load |
| emode_ld | output | 1 | One-cycle strobe on an extended mode load |
| ld_opcode | output | 13 | Op-code of the most recent mode load |
| base_mode | output | 13 | Base mode register |
| ext_mode | output | 13 | Extended mode register |

## Verification
Any wrong bank state is visible at the ports within one cycle, because the state, the row, the burst and the pending precharge of every bank are outputs. A fault that hides in an internal count does not show at once. A precharge wait that is off by one shows up as a wrong flag on the first activate after a precharge. A wrong burst length moves the edge at which an automatic precharge closes its bank. The bench therefore compares every output after every edge against its own model, which it advances one command at a time. That catches such faults on the edge where they first diverge.

// File: rtl/sdram_trk_pkg.sv
// Package: command codes, bank states, error bit positions and the
// burst-length mapping shared by the command tracker modules.
package sdram_trk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_BST   = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_AREF  = 4'd7,
        CMD_SREF  = 4'd8,
        CMD_LMR   = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_PRECH = 2'd2
    } bank_e;

    localparam int ERR_W    = 6;
    localparam int ERR_RW   = 0;
    localparam int ERR_ACT  = 1;
    localparam int ERR_BST  = 2;
    localparam int ERR_REF  = 3;
    localparam int ERR_LMR  = 4;
    localparam int ERR_CKE  = 5;
    localparam int BURST_W  = 3;

    // Maps the burst-length field to clock cycles (two transfers per cycle).
    function automatic logic [BURST_W-1:0] burst_cycles(input logic [2:0] code);
        case (code)
            3'd2:    burst_cycles = 3'd2;
            3'd3:    burst_cycles = 3'd4;
            default: burst_cycles = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: combinational map of the strobe lines to a command code.
// Assumes the strobes are sampled by the caller on the same edge.
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd
);

    // Strobe pattern to command; refresh splits on clock enable.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                default: cmd = CMD_LMR;
            endcase
        end
    end

endmodule

// File: rtl/sdram_mode_regs.sv
// Mode register pair: holds the base and extended mode words.
// Assumes at most one load request per cycle, already checked for legality.
module sdram_mode_regs #(
    parameter int OP_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_base,
    input  logic            ld_ext,
    input  logic [OP_W-1:0] op,
    output logic [OP_W-1:0] base_q,
    output logic [OP_W-1:0] ext_q
);

    // Capture the op-code into whichever register is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ext_q  <= '0;
        end else begin
            if (ld_base) base_q <= op;
            if (ld_ext)  ext_q  <= op;
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_base, ld_ext})); // R10
    AST_BASE_TAKES_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ld_base |=> base_q == $past(op)); // R10

endmodule

// File: rtl/sdram_bank_slot.sv
// One bank: idle/open/precharging state, open row, burst countdown and
// pending automatic precharge. Assumes the go inputs are already legal
// and mutually exclusive (one command per cycle).
module sdram_bank_slot
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int TRP_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_go,
    input  logic               rw_go,
    input  logic               rw_read,
    input  logic               rw_ap,
    input  logic               pre_go,
    input  logic               bst_go,
    input  logic [ROW_W-1:0]   row_in,
    input  logic [BURST_W-1:0] burst_len,
    output bank_e              state,
    output logic [ROW_W-1:0]   row,
    output logic               burst_on,
    output logic               ap_pend,
    output logic               ready,
    output logic               rw_ok,
    output logic               rd_plain
);

    localparam int CNT_W = $clog2(TRP_CYC + 1);
    localparam logic [CNT_W-1:0] TRP_LOAD = CNT_W'(TRP_CYC - 1);

    bank_e              st_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [ROW_W-1:0]   row_q;
    logic [BURST_W-1:0] left_q;
    logic               rd_q;
    logic               ap_q;

    // Readiness and legality views of the current state.
    always_comb begin
        ready    = (st_q == BK_IDLE) || (st_q == BK_PRECH && cnt_q == '0);
        rw_ok    = (st_q == BK_OPEN) && !ap_q;
        rd_plain = (left_q != '0) && rd_q && !ap_q;
    end

    // State progression first, then the decoded command overrides it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BK_IDLE;
            cnt_q  <= '0;
            row_q  <= '0;
            left_q <= '0;
            rd_q   <= 1'b0;
            ap_q   <= 1'b0;
        end else begin
            if (st_q == BK_PRECH) begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                else             st_q  <= BK_IDLE;
            end
            if (left_q != '0) begin
                left_q <= left_q - 1'b1;
                if (left_q == 3'd1 && ap_q) begin
                    st_q  <= BK_PRECH;
                    cnt_q <= TRP_LOAD;
                    ap_q  <= 1'b0;
                end
            end
            if (act_go) begin
                st_q  <= BK_OPEN;
                row_q <= row_in;
            end
            if (rw_go) begin
                left_q <= burst_len;
                rd_q   <= rw_read;
                ap_q   <= rw_ap;
            end
            if (pre_go) begin
                st_q   <= BK_PRECH;
                cnt_q  <= TRP_LOAD;
                left_q <= '0;
                ap_q   <= 1'b0;
            end
            if (bst_go) left_q <= '0;
        end
    end

    assign state    = st_q;
    assign row      = row_q;
    assign burst_on = (left_q != '0);
    assign ap_pend  = ap_q;

    AST_ACT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> ready); // R3
    AST_RW_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        rw_go |-> (st_q == BK_OPEN && !ap_q)); // R4
    AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == 3'd1 && ap_q) |=> st_q == BK_PRECH); // R5
    AST_TRP_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_PRECH && cnt_q == '0) |=> st_q != BK_PRECH); // R7

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Top: decodes each sampled command, checks it against the per-bank state,
// drives the bank slots and mode registers, and registers the command code,
// error flags and load strobes. Assumes one command per clock edge.
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int AP_BIT  = 10,
    parameter int TRP_CYC = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   cke,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BA_W-1:0]        ba,
    output logic [3:0]             cmd_code,
    output logic [ERR_W-1:0]       err_flags,
    output logic [2*(1<<BA_W)-1:0] bank_state,
    output logic [ADDR_W*(1<<BA_W)-1:0] bank_row,
    output logic [(1<<BA_W)-1:0]   burst_on,
    output logic [(1<<BA_W)-1:0]   ap_pend,
    output logic                   mode_ld,
    output logic                   emode_ld,
    output logic [ADDR_W-1:0]      ld_opcode,
    output logic [ADDR_W-1:0]      base_mode,
    output logic [ADDR_W-1:0]      ext_mode
);

    localparam int NB = 1 << BA_W;

    cmd_e               cmd;
    logic               cke_bad;
    logic               ok;
    logic               a10;
    logic [NB-1:0]      ready_v, rw_ok_v, rd_plain_v;
    logic [NB-1:0]      act_go_v, rw_go_v, pre_go_v, bst_go_v;
    logic [ERR_W-1:0]   err_d;
    logic               ld_base, ld_ext;
    logic [BURST_W-1:0] blen;
    cmd_e               cmd_q;
    logic [ERR_W-1:0]   err_q;
    logic               mode_ld_q, emode_ld_q;
    logic [ADDR_W-1:0]  opcode_q;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .cmd   (cmd)
    );

    assign a10  = addr[AP_BIT];
    assign blen = burst_cycles(base_mode[2:0]);

    // Legality of the sampled command against the bank and mode state.
    always_comb begin
        cke_bad = !cke && (cmd != CMD_DESEL) && (cmd != CMD_SREF);
        ok      = !cke_bad;
        err_d   = '0;
        err_d[ERR_CKE] = cke_bad;
        err_d[ERR_ACT] = ok && (cmd == CMD_ACT) && !ready_v[ba];
        err_d[ERR_RW]  = ok && (cmd == CMD_RD || cmd == CMD_WR) && !rw_ok_v[ba];
        err_d[ERR_BST] = ok && (cmd == CMD_BST) && (rd_plain_v == '0);
        err_d[ERR_REF] = ok && (cmd == CMD_AREF || cmd == CMD_SREF) && !(&ready_v);
        err_d[ERR_LMR] = ok && (cmd == CMD_LMR) && (ba > BA_W'(1));
        ld_base        = ok && (cmd == CMD_LMR) && (ba == BA_W'(0));
        ld_ext         = ok && (cmd == CMD_LMR) && (ba == BA_W'(1));
    end

    // Per-bank go signals and slot instances.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        bank_e bstate;
        logic  bsel;
        assign bsel        = (ba == BA_W'(b));
        assign act_go_v[b] = ok && (cmd == CMD_ACT) && bsel && ready_v[b];
        assign rw_go_v[b]  = ok && (cmd == CMD_RD || cmd == CMD_WR) && bsel && rw_ok_v[b];
        assign pre_go_v[b] = ok && (cmd == CMD_PRE) && (a10 || bsel) && rw_ok_v[b];
        assign bst_go_v[b] = ok && (cmd == CMD_BST) && rd_plain_v[b];

        sdram_bank_slot #(
            .ROW_W   (ADDR_W),
            .TRP_CYC (TRP_CYC)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (act_go_v[b]),
            .rw_go     (rw_go_v[b]),
            .rw_read   (cmd == CMD_RD),
            .rw_ap     (a10),
            .pre_go    (pre_go_v[b]),
            .bst_go    (bst_go_v[b]),
            .row_in    (addr),
            .burst_len (blen),
            .state     (bstate),
            .row       (bank_row[ADDR_W*b +: ADDR_W]),
            .burst_on  (burst_on[b]),
            .ap_pend   (ap_pend[b]),
            .ready     (ready_v[b]),
            .rw_ok     (rw_ok_v[b]),
            .rd_plain  (rd_plain_v[b])
        );
        assign bank_state[2*b +: 2] = bstate;
    end

    sdram_mode_regs #(.OP_W(ADDR_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_base (ld_base),
        .ld_ext  (ld_ext),
        .op      (addr),
        .base_q  (base_mode),
        .ext_q   (ext_mode)
    );

    // Registered report of command, flags, strobes and last op-code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_DESEL;
            err_q      <= '0;
            mode_ld_q  <= 1'b0;
            emode_ld_q <= 1'b0;
            opcode_q   <= '0;
        end else begin
            cmd_q      <= cmd;
            err_q      <= err_d;
            mode_ld_q  <= ld_base;
            emode_ld_q <= ld_ext;
            if (ld_base || ld_ext) opcode_q <= addr;
        end
    end

    assign cmd_code  = cmd_q;
    assign err_flags = err_q;
    assign mode_ld   = mode_ld_q;
    assign emode_ld  = emode_ld_q;
    assign ld_opcode = opcode_q;

    AST_IDLE_CMD_KEEPS_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd == CMD_DESEL) |=> $stable(bank_row)); // R2
    AST_BAD_LMR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q[ERR_LMR] |-> !(mode_ld_q || emode_ld_q)); // R10
    AST_CKE_BLOCKS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        cke_bad |-> (act_go_v == '0 && rw_go_v == '0 && pre_go_v == '0)); // R11

endmodule

// File: tb/sdram_cmd_tracker_test.sv
// Bench: fixed-seed random and directed commands, every output compared after
// each edge against a model advanced by bench functions from the requirements.
module sdram_cmd_tracker_test;

    localparam int NB  = 4;
    localparam int TRP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic [3:0]  cmd_code;
    logic [5:0]  err_flags;
    logic [7:0]  bank_state;
    logic [51:0] bank_row;
    logic [3:0]  burst_on, ap_pend;
    logic        mode_ld, emode_ld;
    logic [12:0] ld_opcode, base_mode, ext_mode;

    int n_checks = 0;
    int n_errors = 0;

    sdram_cmd_tracker #(.TRP_CYC(TRP)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .addr(addr), .ba(ba), .cmd_code(cmd_code),
        .err_flags(err_flags), .bank_state(bank_state), .bank_row(bank_row),
        .burst_on(burst_on), .ap_pend(ap_pend), .mode_ld(mode_ld),
        .emode_ld(emode_ld), .ld_opcode(ld_opcode), .base_mode(base_mode),
        .ext_mode(ext_mode)
    );

    always #2 clk = ~clk;

    // Model state
    int          m_st[NB];
    int          m_cnt[NB];
    logic [12:0] m_row[NB];
    int          m_left[NB];
    logic        m_rd[NB];
    logic        m_ap[NB];
    logic [12:0] m_base, m_ext, e_op;
    logic [3:0]  e_cmd;
    logic [5:0]  e_err;
    logic        e_ml, e_eml;

    function automatic logic [3:0] f_decode(input logic c, r, a, w, k);
        if (c) return 4'd0;
        case ({r, a, w})
            3'b111:  return 4'd1;
            3'b011:  return 4'd2;
            3'b101:  return 4'd3;
            3'b100:  return 4'd4;
            3'b110:  return 4'd5;
            3'b010:  return 4'd6;
            3'b001:  return k ? 4'd7 : 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    function automatic int f_blen(input logic [2:0] code);
        return (code == 3'd2) ? 2 : (code == 3'd3) ? 4 : 1;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_st[b] = 0; m_cnt[b] = 0; m_row[b] = '0; m_left[b] = 0;
            m_rd[b] = 1'b0; m_ap[b] = 1'b0;
        end
        m_base = '0; m_ext = '0; e_op = '0; e_cmd = 4'd0; e_err = '0;
        e_ml = 1'b0; e_eml = 1'b0;
    endtask

    task automatic model_step(input logic c, r, a, w, k, input logic [12:0] ad,
                              input logic [1:0] bk);
        logic [3:0] cmd;
        logic rdy[NB], rwok[NB], rdp[NB];
        logic ok, any_rdp, all_rdy;
        int bl;
        cmd = f_decode(c, r, a, w, k);
        any_rdp = 1'b0; all_rdy = 1'b1;
        for (int b = 0; b < NB; b++) begin
            rdy[b]  = (m_st[b] == 0) || (m_st[b] == 2 && m_cnt[b] == 0);
            rwok[b] = (m_st[b] == 1) && !m_ap[b];
            rdp[b]  = (m_left[b] != 0) && m_rd[b] && !m_ap[b];
            any_rdp |= rdp[b];
            all_rdy &= rdy[b];
        end
        bl = f_blen(m_base[2:0]);
        e_err = '0; e_ml = 1'b0; e_eml = 1'b0; e_cmd = cmd;
        ok = !( !k && cmd != 4'd0 && cmd != 4'd8 );
        e_err[5] = !ok;
        for (int b = 0; b < NB; b++) begin
            if (m_st[b] == 2) begin
                if (m_cnt[b] != 0) m_cnt[b]--; else m_st[b] = 0;
            end
            if (m_left[b] != 0) begin
                if (m_left[b] == 1 && m_ap[b]) begin
                    m_st[b] = 2; m_cnt[b] = TRP - 1; m_ap[b] = 1'b0;
                end
                m_left[b]--;
            end
        end
        if (ok) begin
            case (cmd)
                4'd2: if (rdy[bk]) begin m_st[bk] = 1; m_row[bk] = ad; end
                      else e_err[1] = 1'b1;
                4'd3, 4'd4: if (rwok[bk]) begin
                          m_left[bk] = bl; m_rd[bk] = (cmd == 4'd3); m_ap[bk] = ad[10];
                      end else e_err[0] = 1'b1;
                4'd6: for (int b = 0; b < NB; b++)
                          if ((ad[10] || bk == 2'(b)) && rwok[b]) begin
                              m_st[b] = 2; m_cnt[b] = TRP - 1; m_left[b] = 0; m_ap[b] = 1'b0;
                          end
                4'd5: if (any_rdp) begin
                          for (int b = 0; b < NB; b++) if (rdp[b]) m_left[b] = 0;
                      end else e_err[2] = 1'b1;
                4'd7, 4'd8: if (!all_rdy) e_err[3] = 1'b1;
                4'd9: if (bk == 2'd0) begin m_base = ad; e_ml = 1'b1; e_op = ad; end
                      else if (bk == 2'd1) begin m_ext = ad; e_eml = 1'b1; e_op = ad; end
                      else e_err[4] = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0]  es;
        logic [51:0] er;
        logic [3:0]  eb, ea;
        for (int b = 0; b < NB; b++) begin
            es[2*b +: 2] = 2'(m_st[b]);
            er[13*b +: 13] = m_row[b];
            eb[b] = (m_left[b] != 0);
            ea[b] = m_ap[b];
        end
        chk((tag == "") ? "R1" : tag, "cmd_code", 64'(cmd_code), 64'(e_cmd));
        chk((tag == "") ? "R4" : tag, "err_flags", 64'(err_flags), 64'(e_err));
        chk((tag == "") ? "R6" : tag, "bank_state", 64'(bank_state), 64'(es));
        chk((tag == "") ? "R3" : tag, "bank_row", 64'(bank_row), 64'(er));
        chk((tag == "") ? "R4" : tag, "burst_on", 64'(burst_on), 64'(eb));
        chk((tag == "") ? "R5" : tag, "ap_pend", 64'(ap_pend), 64'(ea));
        chk((tag == "") ? "R10" : tag, "mode",
            64'({mode_ld, emode_ld, ld_opcode, base_mode, ext_mode}),
            64'({e_ml, e_eml, e_op, m_base, m_ext}));
    endtask

    // Drive one command on the falling edge, model it, compare after the rise.
    task automatic issue(input logic c, input logic [2:0] enc, input logic k,
                         input logic [12:0] ad, input logic [1:0] bk, input string tag);
        @(negedge clk);
        cs_n = c; {ras_n, cas_n, we_n} = enc; cke = k; addr = ad; ba = bk;
        model_step(c, enc[2], enc[1], enc[0], k, ad, bk);
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    localparam logic [2:0] E_NOP = 3'b111, E_ACT = 3'b011, E_RD = 3'b101,
        E_WR = 3'b100, E_BST = 3'b110, E_PRE = 3'b010, E_REF = 3'b001, E_LMR = 3'b000;

    logic done = 1'b0;

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check_all("R12");
        @(negedge clk);
        rst_n = 1'b1;

        issue(1'b1, E_NOP, 1'b1, 13'h1FFF, 2'd3, "R2");
        issue(1'b0, E_NOP, 1'b1, 13'h0AAA, 2'd2, "R2");
        issue(1'b0, E_LMR, 1'b1, 13'h0003, 2'd0, "R10");
        issue(1'b0, E_LMR, 1'b1, 13'h0040, 2'd1, "R10");
        issue(1'b0, E_LMR, 1'b1, 13'h0555, 2'd2, "R10");
        issue(1'b0, E_ACT, 1'b1, 13'h1ABC, 2'd1, "R3");
        issue(1'b0, E_ACT, 1'b1, 13'h0123, 2'd1, "R3");
        issue(1'b0, E_RD,  1'b1, 13'h0010, 2'd2, "R4");
        issue(1'b0, E_RD,  1'b1, 13'h0010, 2'd1, "R4");
        issue(1'b0, E_BST, 1'b1, 13'h0000, 2'd0, "R8");
        issue(1'b0, E_BST, 1'b1, 13'h0000, 2'd0, "R8");
        issue(1'b0, E_WR,  1'b1, 13'h0400, 2'd1, "R5");
        issue(1'b0, E_BST, 1'b1, 13'h0000, 2'd0, "R8");
        issue(1'b0, E_RD,  1'b1, 13'h0000, 2'd1, "R4");
        for (int i = 0; i < 3; i++) issue(1'b0, E_NOP, 1'b1, 13'h0, 2'd0, "R5");
        issue(1'b0, E_ACT, 1'b1, 13'h0777, 2'd1, "R7");
        issue(1'b0, E_ACT, 1'b1, 13'h0777, 2'd1, "R7");
        issue(1'b0, E_ACT, 1'b1, 13'h0777, 2'd1, "R7");
        issue(1'b0, E_ACT, 1'b1, 13'h0101, 2'd0, "R3");
        issue(1'b0, E_ACT, 1'b1, 13'h0303, 2'd3, "R3");
        issue(1'b0, E_REF, 1'b1, 13'h0, 2'd0, "R9");
        issue(1'b0, E_PRE, 1'b1, 13'h0000, 2'd3, "R6");
        issue(1'b0, E_PRE, 1'b1, 13'h0400, 2'd2, "R6");
        issue(1'b0, E_PRE, 1'b1, 13'h0000, 2'd3, "R6");
        issue(1'b0, E_ACT, 1'b0, 13'h0999, 2'd2, "R11");
        issue(1'b0, E_NOP, 1'b0, 13'h0, 2'd0, "R11");
        issue(1'b0, E_REF, 1'b1, 13'h0, 2'd0, "R9");
        issue(1'b0, E_REF, 1'b0, 13'h0, 2'd0, "R9");
        issue(1'b0, E_REF, 1'b1, 13'h0, 2'd0, "R9");

        for (int i = 0; i < 4000; i++) begin
            logic c, k;
            logic [2:0] enc;
            int pick;
            pick = $urandom_range(0, 99);
            c = (pick < 8);
            k = ($urandom_range(0, 19) != 0);
            case ($urandom_range(0, 11))
                0, 1:    enc = E_ACT;
                2, 3:    enc = E_RD;
                4:       enc = E_WR;
                5:       enc = E_BST;
                6:       enc = E_PRE;
                7:       enc = E_REF;
                8:       enc = E_LMR;
                default: enc = E_NOP;
            endcase
            issue(c, enc, k, 13'($urandom), 2'($urandom), "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule